// File: doc/BRIEF.md
# UART Status Word with Read-Then-Clear Flags

This block holds the 16-bit status word of a FIFO-backed serial port. The high byte is a live view of the receive-error tally supplied by the receive FIFO. The low byte holds eight status flags. Receive and transmit logic raise these flags with one-cycle set pulses.

Software may only drop a flag by writing 0 to its position. The write takes effect only when software has already read the word while that flag was 1, and only if the flag has not been raised again since. Writing 1 never raises a flag.

Two positions, the framing and parity indicators, cannot be written at all. They follow their hardware inputs as levels.

A system reset returns the low byte to 0x60. A synchronous standby input also returns it to 0x60 and discards every record of earlier reads.

Low-byte layout, bit 7 down to bit 0:

| Bit | Flag |
|-----|------|
| 7 | error summary |
| 6 | transmit end |
| 5 | transmit FIFO space |
| 4 | line break |
| 3 | framing error |
| 2 | parity error |
| 1 | receive FIFO full |
| 0 | receive data ready |

Top module: `uart_stat_word`

## Requirements
- R1: After reset, the low byte of `rdata_o` reads 0x60. Bits 6 and 5 are 1 and all other flag bits are 0.
- R2: Bits 15:8 of `rdata_o` equal `err_cnt_i` in the same cycle, whatever is written.
- R3: A 1 on `hw_set_i[k]` for a writable position k (7, 6, 5, 4, 1 or 0) makes bit k read 1 after that clock edge.
- R4: A write of 1 to any bit never makes that bit 1.
- R5: A write of 0 to a set writable flag leaves it at 1 when no read has been done since the flag was set.
- R6: When a read is done while flag k is 1, a later write with bit k = 0 makes bit k read 0 after the write's clock edge.
- R7: If hardware sets flag k again after the read, a following 0 write leaves the flag at 1.
- R8: When a set pulse and a qualifying 0 write on flag k fall in the same cycle, the flag stays 1 and the earlier read no longer counts. A further 0 write then leaves it at 1.
- R9: Bits 3 and 2 are read-only. Each shows the level of its `hw_set_i` bit from the previous clock edge, and writes do not change it.
- R10: A cycle with `stby_i` high makes the low byte read 0x60 after that edge and discards earlier reads. A following 0 write then changes nothing.
- R11: In a write that qualifies for clearing, a flag whose written bit is 1 keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stby_i | input | 1 | Synchronous standby: restores the reset value |
| hw_set_i | input | 8 | Per-flag set pulses; level inputs for bits 3 and 2 |
| err_cnt_i | input | 8 | Receive-error tally from the receive FIFO |
| rd_i | input | 1 | Bus read strobe of the status word |
| wr_i | input | 1 | Bus write strobe of the status word |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Status word read data |

## Verification
The high byte is combinational, so the bench samples it one time step after changing `err_cnt_i`, with no clock edge in between.

Every flag effect is registered. A set pulse, read, write or standby driven at a falling edge is therefore due after the next rising edge. The bench samples it at the following falling edge.

A read records its effect only at that same edge. For this reason, read and write are always placed in separate cycles, and the clear is expected exactly one edge after the write cycle begins.

The bench sweeps every writable position through the set, blocked-clear, allowed-clear, re-set, collision and standby sequences. The two read-only positions get their own sweep.

// File: rtl/uss_pkg.sv
package uss_pkg;
  localparam int FLAG_W = 8;
  localparam int CNT_W  = 8;
  localparam logic [FLAG_W-1:0] FLAG_RST = 8'h60;
  localparam logic [FLAG_W-1:0] RO_MASK  = 8'h0C;

  // a 0-write clears only a writable flag that has been seen set by a read
  function automatic logic clr_qualified(logic writable, logic wr, logic wbit, logic seen);
    return writable & wr & ~wbit & seen;
  endfunction

  function automatic logic [CNT_W+FLAG_W-1:0] pack_word(logic [CNT_W-1:0] cnt,
                                                        logic [FLAG_W-1:0] flags);
    return {cnt, flags};
  endfunction
endpackage

// File: rtl/uss_flag_cell.sv
module uss_flag_cell #(
  parameter logic RST_BIT  = 1'b0,
  parameter logic WRITABLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_i,
  input  logic hw_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  import uss_pkg::*;

  logic flag_q;
  logic seen_q;
  logic clr_evt;   // qualifying software clear this cycle
  logic mark_evt;  // read observed flag at 1

  assign clr_evt  = clr_qualified(WRITABLE, wr_i, wbit_i, seen_q);
  assign mark_evt = rd_i & flag_q;
  assign flag_o   = flag_q;

  generate
    if (WRITABLE) begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          flag_q <= RST_BIT;
          seen_q <= 1'b0;
        end else if (stby_i) begin
          flag_q <= RST_BIT;
          seen_q <= 1'b0;
        end else if (hw_i) begin
          flag_q <= 1'b1;
          seen_q <= 1'b0;
        end else if (clr_evt) begin
          flag_q <= 1'b0;
          seen_q <= 1'b0;
        end else if (mark_evt) begin
          seen_q <= 1'b1;
        end
      end

      AST_HW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_i && !stby_i) |=> flag_q);                                        // R3
      AST_NO_SELF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hw_i && !stby_i && !flag_q) |=> !flag_q);                           // R4
      AST_CLR_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q && !seen_q && !hw_i && !stby_i) |=> flag_q);                  // R5
      AST_QUAL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !wbit_i && seen_q && !hw_i && !stby_i) |=> !flag_q);         // R6
      AST_KEEP_ON_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q && wr_i && wbit_i && !stby_i) |=> flag_q);                    // R11
      AST_SET_DROPS_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_i && !stby_i) |=> (flag_q && !seen_q));                           // R8
      AST_STBY_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stby_i |=> (flag_q == RST_BIT && !seen_q));                           // R10
    end else begin : g_ro
      logic unused_ro_ins;
      assign unused_ro_ins = rd_i ^ wr_i ^ wbit_i ^ clr_evt ^ mark_evt;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          flag_q <= RST_BIT;
        end else if (stby_i) begin
          flag_q <= RST_BIT;
        end else begin
          flag_q <= hw_i;
        end
      end
      assign seen_q = 1'b0;

      AST_RO_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stby_i |=> (flag_q == $past(hw_i)));                                 // R9
    end
  endgenerate
endmodule

// File: rtl/uss_rd_word.sv
module uss_rd_word #(
  parameter int CNT_W  = 8,
  parameter int FLAG_W = 8
) (
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [FLAG_W-1:0]       flags_i,
  output logic [CNT_W+FLAG_W-1:0] word_o
);
  import uss_pkg::*;
  assign word_o = pack_word(cnt_i, flags_i);
endmodule

// File: rtl/uart_stat_word.sv
module uart_stat_word #(
  parameter int                           CNT_W  = uss_pkg::CNT_W,
  parameter int                           FLAG_W = uss_pkg::FLAG_W,
  parameter logic [uss_pkg::FLAG_W-1:0]   RST_VAL = uss_pkg::FLAG_RST,
  parameter logic [uss_pkg::FLAG_W-1:0]   RO_BITS = uss_pkg::RO_MASK
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    stby_i,
  input  logic [FLAG_W-1:0]       hw_set_i,
  input  logic [CNT_W-1:0]        err_cnt_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [CNT_W+FLAG_W-1:0] wdata_i,
  output logic [CNT_W+FLAG_W-1:0] rdata_o
);
  localparam int WORD_W = CNT_W + FLAG_W;

  logic [FLAG_W-1:0] flags;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wdata_i[WORD_W-1:FLAG_W];

  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
    uss_flag_cell #(
      .RST_BIT  (RST_VAL[k]),
      .WRITABLE (!RO_BITS[k])
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stby_i (stby_i),
      .hw_i   (hw_set_i[k]),
      .rd_i   (rd_i),
      .wr_i   (wr_i),
      .wbit_i (wdata_i[k]),
      .flag_o (flags[k])
    );
  end

  uss_rd_word #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_rd (
    .cnt_i   (err_cnt_i),
    .flags_i (flags),
    .word_o  (rdata_o)
  );

  AST_STBY_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> (rdata_o[FLAG_W-1:0] == RST_VAL));                             // R10
  AST_RO_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stby_i && (hw_set_i & RO_BITS) == '0) |=> ((rdata_o[FLAG_W-1:0] & RO_BITS) == '0)); // R9
endmodule

// File: tb/uart_stat_word_test.sv
module uart_stat_word_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stby = 1'b0;
  logic [7:0]  hs = 8'h00;
  logic [7:0]  cnt = 8'h00;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wd = 16'h0000;
  logic [15:0] rdata;
  int checks = 0;
  int fails  = 0;

  uart_stat_word uut (
    .clk_i(clk), .rst_ni(rst_n), .stby_i(stby), .hw_set_i(hs), .err_cnt_i(cnt),
    .rd_i(rd), .wr_i(wr), .wdata_i(wd), .rdata_o(rdata)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] s, input logic r, input logic w,
                     input logic [15:0] d, input logic sb);
    hs = s; rd = r; wr = w; wd = d; stby = sb;
    @(posedge clk);
    @(negedge clk);
    hs = 8'h00; rd = 1'b0; wr = 1'b0; wd = 16'h0000; stby = 1'b0;
  endtask

  task automatic lo(input string req, input logic [7:0] exp);
    chk(req, {8'h00, rdata[7:0]}, {8'h00, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int wbits[6] = '{7, 6, 5, 4, 1, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    lo("R1 reset value", 8'h60);

    for (int v = 0; v < 256; v++) begin
      cnt = v[7:0];
      wd = 16'h00FF;
      #1;
      chk("R2 live count", {8'h00, rdata[15:8]}, {8'h00, v[7:0]});
    end
    wd = 16'h0000;

    // drop the two reset-high flags through read then 0-write
    cyc(8'h00, 1'b0, 1'b1, 16'h0000, 1'b0);
    lo("R5 unread reset flags stay", 8'h60);
    cyc(8'h00, 1'b1, 1'b0, 16'h0000, 1'b0);
    cyc(8'h00, 1'b0, 1'b1, 16'h0000, 1'b0);
    lo("R6 clear after read", 8'h00);

    foreach (wbits[i]) begin
      logic [7:0] m;
      m = 8'h01 << wbits[i];
      cyc(8'h00, 1'b0, 1'b1, 16'hFFFF, 1'b0);
      lo("R4 write one no set", 8'h00);
      cyc(m, 1'b0, 1'b0, 16'h0000, 1'b0);
      lo("R3 hardware set", m);
      cyc(8'h00, 1'b0, 1'b1, 16'h0000, 1'b0);
      lo("R5 clear without read", m);
      cyc(8'h00, 1'b1, 1'b0, 16'h0000, 1'b0);
      cyc(8'h00, 1'b0, 1'b1, {8'h00, m}, 1'b0);
      lo("R11 written one keeps flag", m);
      cyc(8'h00, 1'b0, 1'b1, {8'hFF, ~m}, 1'b0);
      lo("R6 read then clear", 8'h00);

      cyc(m, 1'b0, 1'b0, 16'h0000, 1'b0);
      cyc(8'h00, 1'b1, 1'b0, 16'h0000, 1'b0);
      cyc(m, 1'b0, 1'b0, 16'h0000, 1'b0);
      cyc(8'h00, 1'b0, 1'b1, 16'h0000, 1'b0);
      lo("R7 re-set voids read", m);
      cyc(8'h00, 1'b1, 1'b0, 16'h0000, 1'b0);
      cyc(8'h00, 1'b0, 1'b1, 16'h0000, 1'b0);
      lo("R7 fresh read clears", 8'h00);

      cyc(m, 1'b0, 1'b0, 16'h0000, 1'b0);
      cyc(8'h00, 1'b1, 1'b0, 16'h0000, 1'b0);
      cyc(m, 1'b0, 1'b1, 16'h0000, 1'b0);
      lo("R8 set beats clear", m);
      cyc(8'h00, 1'b0, 1'b1, 16'h0000, 1'b0);
      lo("R8 read voided by collision", m);
      cyc(8'h00, 1'b1, 1'b0, 16'h0000, 1'b0);
      cyc(8'h00, 1'b0, 1'b1, 16'h0000, 1'b0);
      lo("R8 cleared after new read", 8'h00);

      cyc(m, 1'b0, 1'b0, 16'h0000, 1'b0);
      cyc(8'h00, 1'b1, 1'b0, 16'h0000, 1'b0);
      cyc(8'h00, 1'b0, 1'b0, 16'h0000, 1'b1);
      lo("R10 standby restores", 8'h60);
      cyc(8'h00, 1'b0, 1'b1, 16'h0000, 1'b0);
      lo("R10 standby drops reads", 8'h60);
      cyc(8'h00, 1'b1, 1'b0, 16'h0000, 1'b0);
      cyc(8'h00, 1'b0, 1'b1, 16'h0000, 1'b0);
      lo("R10 cleanup", 8'h00);
    end

    for (int b = 2; b <= 3; b++) begin
      logic [7:0] m;
      m = 8'h01 << b;
      cyc(m, 1'b0, 1'b0, 16'h0000, 1'b0);
      lo("R9 follows level", m);
      cyc(m, 1'b1, 1'b0, 16'h0000, 1'b0);
      cyc(m, 1'b0, 1'b1, 16'h0000, 1'b0);
      lo("R9 zero write ignored", m);
      cyc(8'h00, 1'b0, 1'b0, 16'h0000, 1'b0);
      lo("R9 drops with level", 8'h00);
      cyc(8'h00, 1'b0, 1'b1, 16'hFFFF, 1'b0);
      lo("R9 one write ignored", 8'h00);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule